// File: doc/BRIEF.md
# Device Descriptor Header Checker

This block checks the fixed 22-byte header at the front of a device descriptor image. The image arrives one byte per accepted cycle. A start flag marks the first byte and an end flag marks the last. The block keeps no copy of the image. It runs two CRC engines over the bytes as they pass and captures the header fields into registers. When the last byte has been accepted, it reports a verdict.

The verdict separates fatal problems from advisory ones:

- **Fatal:** a length that does not match the number of bytes received, a frame too short to hold a full header, or a bad identifier checksum.
- **Advisory:** a bad checksum over the data area, or a revision number above the supported range.

The captured identifier, vendor, model, revision and declared length stay on the outputs until the next frame begins. Reading the storage device and parsing the entries behind the header are left to neighbouring logic.

Top module: `hdr_checker`

## Requirements
- R1: A frame opens on a byte with `in_valid` and `in_sof` both high. Bytes that arrive while no frame is open are ignored. They produce no `done` and leave the captured fields unchanged.
- R2: Byte 0 is checked against a CRC-8 over bytes 1 to 8. The CRC-8 starts at 0xFF, uses polynomial 0x07, shifts MSB first and has no final inversion. A mismatch sets `uid_crc_err` and `fatal`.
- R3: Bytes 9 to 12, read little-endian, are checked against a CRC-32 over every byte from offset 13 to the end of the frame. The CRC-32 is reflected, uses polynomial 0x82F63B78, starts at all ones and is inverted at the end. A mismatch sets `data_crc_err` only; `fatal` stays low.
- R4: `data_len` is bits 9:0 of the little-endian word at bytes 14 and 15. If the number of bytes received differs from `data_len` + 13, `size_err` and `fatal` are set.
- R5: A frame of fewer than 22 bytes sets `size_err` and `fatal`, even when its byte count equals `data_len` + 13.
- R6: `revision` is byte 13. A value above 2 sets `rev_warn` and leaves `fatal` low. A value of 2 raises no warning.
- R7: `uid` is bytes 1 to 8, `vendor_id` is bytes 16 and 17, and `model_id` is bytes 18 and 19, all little-endian. These fields hold their values from the report until the next frame opens.
- R8: `done` and every status flag are high for exactly the one cycle after the clock edge that accepts the end byte. They are low in every other cycle.
- R9: A start byte inside an open frame drops the partial frame and starts a new one at offset 0.
- R10: Bits 7:2 of byte 15 do not affect `data_len` or the size check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_data` is present this cycle |
| in_data | input | 8 | Image byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| done | output | 1 | One-cycle pulse: the report is valid |
| fatal | output | 1 | Header unusable |
| size_err | output | 1 | Length or minimum-size violation |
| uid_crc_err | output | 1 | Identifier CRC-8 mismatch |
| data_crc_err | output | 1 | Data-area CRC-32 mismatch (advisory) |
| rev_warn | output | 1 | Revision above the supported value |
| data_len | output | 10 | Declared data-area length |
| uid | output | 64 | Captured identifier |
| vendor_id | output | 16 | Captured vendor field |
| model_id | output | 16 | Captured model field |
| revision | output | 8 | Captured revision byte |

## Verification
The assertions assume the following about the inputs:

- `in_sof` and `in_eof` are only meaningful when `in_valid` is high.
- All inputs are known once reset is released.
- A frame is never longer than the byte counter can count, so the counter never saturates.

The bench drives every input on the falling edge and holds `in_valid` low during idle gaps. Its frames are at most 64 bytes long, far below the counter limit. Some frames contain stall cycles, to show that a gap in `in_valid` does not shift any offset.

// File: rtl/hdr_chk_pkg.sv
package hdr_chk_pkg;

  // Header fields collected while the image streams past
  typedef struct packed {
    logic [7:0]  id_sum;     // stored identifier CRC-8
    logic [31:0] body_sum;   // stored data-area CRC-32
    logic [63:0] uid;
    logic [7:0]  rev;
    logic [15:0] len_word;
    logic [15:0] vendor;
    logic [15:0] model;
  } hdr_fields_t;

  localparam int HDR_BYTES  = 22;
  localparam int BODY_START = 13;

endpackage

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
  parameter int          W       = 8,
  parameter logic [W-1:0] POLY   = W'(7),
  parameter logic [W-1:0] INIT   = '1,
  parameter bit          REFLECT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_now
);

  logic [W-1:0] crc_d;

  generate
    if (REFLECT) begin : g_lsb_first
      always_comb begin
        crc_d = crc_q ^ W'(din);
        for (int b = 0; b < 8; b++)
          crc_d = crc_d[0] ? ((crc_d >> 1) ^ POLY) : (crc_d >> 1);
      end
    end else begin : g_msb_first
      always_comb begin
        crc_d = crc_q ^ (W'(din) << (W - 8));
        for (int b = 0; b < 8; b++)
          crc_d = crc_d[W-1] ? ((crc_d << 1) ^ POLY) : (crc_d << 1);
      end
    end
  endgenerate

  assign crc_now = en ? crc_d : crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= INIT;
    else if (en)      crc_q <= crc_d;
  end

  // R2/R3: a new frame always starts the checksum from its seed
  a_r3_clear_loads_seed: assert property (@(posedge clk) disable iff (rst)
    clear |=> crc_q == INIT);

endmodule

// File: rtl/hdr_field_capture.sv
module hdr_field_capture
  import hdr_chk_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              take,
  output logic [CNT_W-1:0]  cur_idx,
  output hdr_fields_t       fld_d,
  output hdr_fields_t       fld_q
);

  logic             open_q;
  logic [CNT_W-1:0] idx_q;

  assign take    = in_valid && (in_sof || open_q);
  assign cur_idx = in_sof ? '0 : idx_q;

  always_comb begin
    fld_d = fld_q;
    if (take) begin
      if (in_sof) fld_d = '0;
      if (cur_idx == CNT_W'(0)) fld_d.id_sum = in_data;
      for (int k = 0; k < 8; k++)
        if (cur_idx == CNT_W'(1 + k)) fld_d.uid[8*k +: 8] = in_data;
      for (int k = 0; k < 4; k++)
        if (cur_idx == CNT_W'(9 + k)) fld_d.body_sum[8*k +: 8] = in_data;
      if (cur_idx == CNT_W'(13)) fld_d.rev = in_data;
      for (int k = 0; k < 2; k++) begin
        if (cur_idx == CNT_W'(14 + k)) fld_d.len_word[8*k +: 8] = in_data;
        if (cur_idx == CNT_W'(16 + k)) fld_d.vendor[8*k +: 8]   = in_data;
        if (cur_idx == CNT_W'(18 + k)) fld_d.model[8*k +: 8]    = in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      idx_q  <= '0;
      fld_q  <= '0;
    end else begin
      fld_q <= fld_d;
      if (take) begin
        open_q <= !in_eof;
        if (cur_idx != '1) idx_q <= cur_idx + CNT_W'(1);
      end
    end
  end

  // R9: a start byte always restarts the offset count
  a_r9_sof_restarts: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> idx_q == CNT_W'(1));

  // R1: bytes outside an open frame leave the captured header alone
  a_r1_idle_ignored: assert property (@(posedge clk) disable iff (rst)
    (!open_q && in_valid && !in_sof) |=> $stable(fld_q));

endmodule

// File: rtl/hdr_checker.sv
module hdr_checker
  import hdr_chk_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int LEN_W   = 10,
  parameter int MAX_REV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              done,
  output logic              fatal,
  output logic              size_err,
  output logic              uid_crc_err,
  output logic              data_crc_err,
  output logic              rev_warn,
  output logic [LEN_W-1:0]  data_len,
  output logic [63:0]       uid,
  output logic [15:0]       vendor_id,
  output logic [15:0]       model_id,
  output logic [7:0]        revision
);

  localparam int TW = CNT_W + 1;

  logic             take;
  logic [CNT_W-1:0] cur_idx;
  hdr_fields_t      fld_d, fld_q;
  logic [7:0]       id_crc_q, id_crc_now;
  logic [31:0]      body_crc_q, body_crc_now;
  logic             id_en, body_en, last;
  logic [TW-1:0]    total, want;
  logic [LEN_W-1:0] len_now;

  hdr_field_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .take(take), .cur_idx(cur_idx),
    .fld_d(fld_d), .fld_q(fld_q)
  );

  assign id_en   = take && (cur_idx >= CNT_W'(1)) && (cur_idx <= CNT_W'(8));
  assign body_en = take && (cur_idx >= CNT_W'(BODY_START));

  crc_byte_engine #(.W(8), .POLY(8'h07), .INIT(8'hFF), .REFLECT(1'b0)) u_id_crc (
    .clk(clk), .rst(rst), .clear(take && in_sof), .en(id_en), .din(in_data),
    .crc_q(id_crc_q), .crc_now(id_crc_now)
  );

  crc_byte_engine #(.W(32), .POLY(32'h82F63B78), .INIT(32'hFFFFFFFF), .REFLECT(1'b1)) u_body_crc (
    .clk(clk), .rst(rst), .clear(take && in_sof), .en(body_en), .din(in_data),
    .crc_q(body_crc_q), .crc_now(body_crc_now)
  );

  assign last    = take && in_eof;
  assign len_now = fld_d.len_word[LEN_W-1:0];
  assign total   = TW'(cur_idx) + TW'(1);
  assign want    = TW'(len_now) + TW'(BODY_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; fatal <= 1'b0; size_err <= 1'b0;
      uid_crc_err <= 1'b0; data_crc_err <= 1'b0; rev_warn <= 1'b0;
    end else if (last) begin
      done         <= 1'b1;
      size_err     <= (total != want) || (total < TW'(HDR_BYTES));
      uid_crc_err  <= id_crc_now != fld_d.id_sum;
      fatal        <= (total != want) || (total < TW'(HDR_BYTES)) ||
                      (id_crc_now != fld_d.id_sum);
      data_crc_err <= ~body_crc_now != fld_d.body_sum;
      rev_warn     <= fld_d.rev > 8'(MAX_REV);
    end else begin
      done <= 1'b0; fatal <= 1'b0; size_err <= 1'b0;
      uid_crc_err <= 1'b0; data_crc_err <= 1'b0; rev_warn <= 1'b0;
    end
  end

  assign data_len  = fld_q.len_word[LEN_W-1:0];
  assign uid       = fld_q.uid;
  assign vendor_id = fld_q.vendor;
  assign model_id  = fld_q.model;
  assign revision  = fld_q.rev;

  // R8: the report follows the end byte by exactly one edge
  a_r8_done_after_end: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && (in_sof || $past(!done || done))) && take |=> done);

  // R8: no status flag outside the report cycle
  a_r8_flags_in_report: assert property (@(posedge clk) disable iff (rst)
    (fatal || data_crc_err || rev_warn || size_err || uid_crc_err) |-> done);

  // R6: a revision warning agrees with the captured revision byte
  a_r6_warn_matches_rev: assert property (@(posedge clk) disable iff (rst)
    (done && rev_warn) |-> revision > 8'(MAX_REV));

  // R3: a data checksum mismatch alone never makes the header fatal
  a_r3_data_not_fatal: assert property (@(posedge clk) disable iff (rst)
    (done && fatal) |-> (size_err || uid_crc_err));

endmodule

// File: tb/tb_hdr_checker.sv
module tb_hdr_checker;
  localparam int CLK_P = 10;

  typedef struct packed {
    int dlen; int extra; int rev; int hi;
    bit bad_uid; bit bad_data;
    bit e_size; bit e_uid; bit e_data; bit e_rev;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{9,  0, 1, 0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // clean minimum frame
    '{20, 0, 3, 0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 rev 3 warns
    '{9,  0, 0, 0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 bad id sum
    '{15, 0, 1, 0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 bad body sum
    '{12, 1, 1, 0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 one byte too many
    '{9,  0, 1, 42, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R10 high bits ignored
    '{5,  0, 1, 0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 18-byte frame
    '{40, 0, 2, 0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}   // R6 rev 2 no warning
  };

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic done, fatal, size_err, uid_crc_err, data_crc_err, rev_warn;
  logic [9:0] data_len;
  logic [63:0] uid;
  logic [15:0] vendor_id, model_id;
  logic [7:0] revision;

  int checks = 0, errors = 0;
  logic [7:0] img [0:63];

  always #(CLK_P/2) clk = ~clk;

  hdr_checker dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .done(done), .fatal(fatal),
    .size_err(size_err), .uid_crc_err(uid_crc_err), .data_crc_err(data_crc_err),
    .rev_warn(rev_warn), .data_len(data_len), .uid(uid), .vendor_id(vendor_id),
    .model_id(model_id), .revision(revision)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sum8(input int first, input int lastb);
    logic [7:0] c = 8'hFF;
    for (int i = first; i <= lastb; i++) begin
      c ^= img[i];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] sum32(input int first, input int lastb);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = first; i <= lastb; i++) begin
      c ^= {24'h0, img[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    end
    return ~c;
  endfunction

  // stream img[0..n-1]; a stall cycle after every 7th byte
  task automatic send(input int n, input bit with_sof, input bit with_eof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = img[i];
      in_sof = with_sof && (i == 0);
      in_eof = with_eof && (i == n - 1);
      if (i % 7 == 6 && i != n - 1) begin
        @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic build(input int v, output int n, output logic [63:0] u,
                       output logic [15:0] ven, output logic [15:0] mdl);
    vec_t t = VECS[v];
    logic [7:0] s8;
    logic [31:0] s32;
    n = t.dlen + 13 + t.extra;
    u = 64'h1122334455667788 + 64'(v) * 64'h0101;
    ven = 16'h1A2B + 16'(v);
    mdl = 16'h3C40 + 16'(v);
    for (int i = 0; i < 64; i++) img[i] = 8'(i * 7 + v);
    for (int k = 0; k < 8; k++) img[1 + k] = u[8*k +: 8];
    img[13] = 8'(t.rev);
    img[14] = 8'(t.dlen);
    img[15] = {6'(t.hi), 2'(t.dlen >> 8)};
    img[16] = ven[7:0]; img[17] = ven[15:8];
    img[18] = mdl[7:0]; img[19] = mdl[15:8];
    s8 = sum8(1, 8) ^ (t.bad_uid ? 8'h01 : 8'h00);
    img[0] = s8;
    s32 = sum32(13, n - 1) ^ (t.bad_data ? 32'h0000_0100 : 32'h0);
    for (int k = 0; k < 4; k++) img[9 + k] = s32[8*k +: 8];
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [63:0] u;
    logic [15:0] ven, mdl;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R8, R7)
    chk("R8 reset done", done, 0);
    chk("R8 reset fatal", fatal, 0);
    chk("R7 reset uid", uid, 0);
    chk("R4 reset len", data_len, 0);

    for (int v = 0; v < NV; v++) begin
      build(v, n, u, ven, mdl);
      send(n, 1'b1, 1'b1);
      chk($sformatf("R8 v%0d done", v), done, 1);
      chk($sformatf("R4 R5 v%0d size_err", v), size_err, VECS[v].e_size);
      chk($sformatf("R2 v%0d uid_crc_err", v), uid_crc_err, VECS[v].e_uid);
      chk($sformatf("R3 v%0d data_crc_err", v), data_crc_err, VECS[v].e_data);
      chk($sformatf("R6 v%0d rev_warn", v), rev_warn, VECS[v].e_rev);
      chk($sformatf("R2 R4 v%0d fatal", v), fatal, VECS[v].e_size | VECS[v].e_uid);
      chk($sformatf("R10 v%0d data_len", v), data_len, 64'(VECS[v].dlen));
      if (n >= 22) begin
        chk($sformatf("R7 v%0d uid", v), uid, u);
        chk($sformatf("R7 v%0d vendor", v), vendor_id, ven);
        chk($sformatf("R7 v%0d model", v), model_id, mdl);
        chk($sformatf("R6 v%0d revision", v), revision, 64'(VECS[v].rev));
      end
      @(negedge clk);
      chk($sformatf("R8 v%0d done pulse ends", v), done, 0);
      chk($sformatf("R8 v%0d flags clear", v), {fatal, data_crc_err, rev_warn}, 0);
      chk($sformatf("R7 v%0d uid held", v), uid, (n >= 22) ? u : uid);
    end

    // R1: bytes without an open frame are ignored
    build(0, n, u, ven, mdl);
    send(n, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) img[i] = 8'hC3;
    send(10, 1'b0, 1'b1);
    chk("R1 no done for stray bytes", done, 0);
    chk("R1 uid unchanged", uid, u);
    chk("R1 vendor unchanged", vendor_id, ven);

    // R9: restart in the middle of a frame
    for (int i = 0; i < 12; i++) img[i] = 8'h5A;
    send(12, 1'b1, 1'b0);
    chk("R9 no done on partial frame", done, 0);
    build(7, n, u, ven, mdl);
    send(n, 1'b1, 1'b1);
    chk("R9 restarted done", done, 1);
    chk("R9 restarted fatal", fatal, 0);
    chk("R9 restarted data crc", data_crc_err, 0);
    chk("R9 restarted uid", uid, u);

    // R5: very short frame
    build(0, n, u, ven, mdl);
    send(10, 1'b1, 1'b1);
    chk("R5 short done", done, 1);
    chk("R5 short size_err", size_err, 1);
    chk("R5 short fatal", fatal, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule